// File: doc/BRIEF.md
# External Interrupt Request Controller

This block gathers external interrupt sources into a single latched request for the CPU. A dedicated request input is OR-combined with a set of port pins, and each port pin joins the combination only when its static enable is set. Whether a pin is configured as an input or an output does not matter. A static mode input chooses between two trigger modes. In edge-only mode, a rising transition of the combined line latches a request. In edge-plus-level mode, any cycle in which the combined line is high latches a request, so service continues while any wired-OR source holds its line high.

Software reaches the controller through one 8-bit status and control word on a simple register bus. The bus has an address, a write strobe, write data and combinational read data. The word holds a read/write enable bit, a read-only pending flag and a write-only clear bit. The request sent to the CPU is the pending flag, qualified by the enable bit and by the CPU's global interrupt mask. All input lines are assumed to be synchronous to `clk` already.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset the enable bit (bit 7) is 1 and the pending flag (bit 3) is 0, so reading address 0x0A returns 0x80.
- R2: The combined request line is `irq_in` OR the OR of (`port_pins` AND `pin_en`). A port pin whose enable is 0 never sets the flag.
- R3: With `level_mode` = 0 (edge-only), a low-to-high change of the combined line sets the flag. The flag reads 1 one cycle after the line rises.
- R4: In edge-only mode, a line that stays high does not re-latch after a clear. A new request needs the line to go low for at least one cycle and then rise again.
- R5: With `level_mode` = 1 (edge-plus-level), the flag is set in every cycle in which the combined line is high.
- R6: A write to 0x0A with bit 1 = 1 clears the flag on the next edge when no trigger occurs in that cycle. A write with bit 1 = 0 leaves the flag unchanged.
- R7: Bit 7 is read/write and takes the written value. Bit 3 is read-only, and writing it has no effect on the flag.
- R8: Bits 6, 5, 4, 2, 1 and 0 always read 0, reads of any address other than 0x0A return 0x00, and writes to other addresses change nothing.
- R9: `irq_to_cpu` = flag AND enable AND NOT `cpu_mask`. The flag still latches while the enable bit is 0.
- R10: If a clear write and a trigger fall in the same cycle, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 1 | Dedicated external request line, active high |
| port_pins | input | 4 | Port pin levels that may act as extra sources |
| pin_en | input | 4 | Static per-pin source enables |
| level_mode | input | 1 | Static trigger mode: 0 edge-only, 1 edge-plus-level |
| cpu_mask | input | 1 | CPU global interrupt mask |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data, combinational |
| irq_to_cpu | output | 1 | Interrupt request to the CPU |

## Verification
A software clear and a new trigger can land in the same cycle. The bench provokes this by issuing the clear write while the combined line is held high. The line is held high either by a just-risen edge or, in edge-plus-level mode, by a level that persists. In edge-plus-level mode the flag must survive the clear. In edge-only mode, with the line already high, the same write must drop the flag. The bench sweeps every source pattern under every pin-enable mask in both modes, and it computes the expected flag from the OR of the enabled sources.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  // Bit positions inside the status/control word
  localparam int EN_BIT   = 7;
  localparam int FLAG_BIT = 3;
  localparam int CLR_BIT  = 1;

  typedef enum logic {
    TRIG_EDGE       = 1'b0,
    TRIG_EDGE_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/extirq_combine.sv
module extirq_combine #(
  parameter int NUM_PINS = 4
) (
  input  logic                irq_in,
  input  logic [NUM_PINS-1:0] port_pins,
  input  logic [NUM_PINS-1:0] pin_en,
  output logic                req_line
);
  logic [NUM_PINS-1:0] gated;

  // Each port pin joins the wired-OR only when its enable is set
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_gate
    assign gated[g] = port_pins[g] & pin_en[g];
  end

  assign req_line = irq_in | (|gated);
endmodule

// File: rtl/extirq_trigger.sv
module extirq_trigger
  import extirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_line,
  input  logic level_mode,
  output logic trig
);
  logic       req_d;
  trig_mode_e mode;

  assign mode = trig_mode_e'(level_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_d <= 1'b0;
    else        req_d <= req_line;
  end

  always_comb begin
    unique case (mode)
      TRIG_EDGE_LEVEL: trig = req_line;
      default:         trig = req_line & ~req_d;
    endcase
  end
endmodule

// File: rtl/extirq_csr.sv
module extirq_csr
  import extirq_pkg::*;
#(
  parameter int              AW       = 8,
  parameter int              DW       = 8,
  parameter logic [AW-1:0]   REG_ADDR = 8'h0A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          trig,
  output logic [DW-1:0] bus_rdata,
  output logic          flag_q,
  output logic          en_q
);
  localparam logic [DW-1:0] WR_MASK = DW'(1) << EN_BIT;
  localparam logic [DW-1:0] RST_VAL = DW'(1) << EN_BIT;

  logic          hit;
  logic          wr_hit;
  logic          clr;
  logic [DW-1:0] ctl_q;
  logic [DW-1:0] rd_word;

  assign hit    = (bus_addr == REG_ADDR);
  assign wr_hit = hit & bus_wr;
  assign clr    = wr_hit & bus_wdata[CLR_BIT];

  // Writable control bits: only those in WR_MASK are stored
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= RST_VAL;
    else if (wr_hit) ctl_q <= (bus_wdata & WR_MASK) | (ctl_q & ~WR_MASK);
  end

  // Pending flag: a trigger outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag_q <= 1'b0;
    else if (trig) flag_q <= 1'b1;
    else if (clr)  flag_q <= 1'b0;
  end

  assign en_q = ctl_q[EN_BIT];

  always_comb begin
    rd_word           = ctl_q & WR_MASK;
    rd_word[FLAG_BIT] = flag_q;
  end

  assign bus_rdata = hit ? rd_word : '0;
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl #(
  parameter int            NUM_PINS = 4,
  parameter int            AW       = 8,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] REG_ADDR = 8'h0A
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                irq_in,
  input  logic [NUM_PINS-1:0] port_pins,
  input  logic [NUM_PINS-1:0] pin_en,
  input  logic                level_mode,
  input  logic                cpu_mask,
  input  logic [AW-1:0]       bus_addr,
  input  logic                bus_wr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic                irq_to_cpu
);
  logic req_line;
  logic trig;
  logic flag_q;
  logic en_q;

  extirq_combine #(.NUM_PINS(NUM_PINS)) u_comb (
    .irq_in    (irq_in),
    .port_pins (port_pins),
    .pin_en    (pin_en),
    .req_line  (req_line)
  );

  extirq_trigger u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_line   (req_line),
    .level_mode (level_mode),
    .trig       (trig)
  );

  extirq_csr #(.AW(AW), .DW(DW), .REG_ADDR(REG_ADDR)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .trig      (trig),
    .bus_rdata (bus_rdata),
    .flag_q    (flag_q),
    .en_q      (en_q)
  );

  assign irq_to_cpu = flag_q & en_q & ~cpu_mask;
endmodule

// File: rtl/extirq_chk.sv
module extirq_chk #(
  parameter int            AW       = 8,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] REG_ADDR = 8'h0A
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_line,
  input logic          level_mode,
  input logic          cpu_mask,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          flag_q,
  input logic          irq_to_cpu
);
  localparam logic [DW-1:0] ZERO_MASK = ~((DW'(1) << 7) | (DW'(1) << 3));

  logic started;
  logic clr_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  assign clr_wr = bus_wr && (bus_addr == REG_ADDR) && bus_wdata[1];

  assert_edge_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    started && req_line && !$past(req_line) |=> flag_q);

  assert_no_relatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    started && !level_mode && req_line && $past(req_line) && clr_wr |=> !flag_q);

  assert_level_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    level_mode && req_line |=> flag_q);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && !req_line |=> !flag_q);

  assert_zero_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ZERO_MASK) == '0);

  assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_mask || !flag_q) |-> !irq_to_cpu);

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr_wr |=> flag_q);
endmodule

bind extirq_ctrl extirq_chk #(.AW(AW), .DW(DW), .REG_ADDR(REG_ADDR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_line   (req_line),
  .level_mode (level_mode),
  .cpu_mask   (cpu_mask),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .flag_q     (flag_q),
  .irq_to_cpu (irq_to_cpu)
);

// File: tb/sim_extirq_ctrl.sv
`timescale 1ns/1ps
module sim_extirq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irq_in = 1'b0;
  logic [3:0] port_pins = '0;
  logic [3:0] pin_en = '0;
  logic       level_mode = 1'b0;
  logic       cpu_mask = 1'b0;
  logic [7:0] bus_addr = 8'h0A;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_to_cpu;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  extirq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .port_pins(port_pins),
    .pin_en(pin_en), .level_mode(level_mode), .cpu_mask(cpu_mask),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_to_cpu(irq_to_cpu)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h0A; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata; bus_addr = 8'h0A;
  endtask

  task automatic srcs(input logic [4:0] p);
    irq_in = p[0]; port_pins = p[4:1];
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r;
    logic       exp_hit;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h0A, r); check("R1 reset word", r, 8'h80);
    check("R1 irq idle", {7'd0, irq_to_cpu}, 8'h00);

    // Exhaustive sweep: mode x pin enables x source patterns (R2..R6, R10)
    for (int m = 0; m < 2; m++) begin
      for (int e = 0; e < 16; e++) begin
        for (int p = 0; p < 32; p++) begin
          level_mode = m[0]; pin_en = e[3:0]; srcs(5'd0);
          wr(8'h0A, 8'h82);
          @(negedge clk);
          srcs(p[4:0]);
          exp_hit = p[0] | (|(p[4:1] & e[3:0]));
          @(negedge clk);
          rd(8'h0A, r);
          check(m ? "R5 level latch" : "R2 R3 edge latch", r, exp_hit ? 8'h88 : 8'h80);
          // clear while line held: R10 in level mode, R4 in edge mode
          wr(8'h0A, 8'h82);
          rd(8'h0A, r);
          check(m ? "R10 clear vs trigger" : "R4 no relatch",
                r, (exp_hit && m == 1) ? 8'h88 : 8'h80);
          // low then high again re-arms edge mode
          srcs(5'd0); @(negedge clk);
          wr(8'h0A, 8'h82);
          srcs(p[4:0]); @(negedge clk);
          rd(8'h0A, r);
          check("R4 re-arm after low", r, exp_hit ? 8'h88 : 8'h80);
        end
      end
    end

    // R6 write with clear bit 0 keeps flag; clear bit 1 clears
    level_mode = 1'b0; pin_en = 4'h0; srcs(5'd0);
    @(negedge clk); srcs(5'd1); @(negedge clk);
    wr(8'h0A, 8'h80); rd(8'h0A, r); check("R6 write zero no effect", r, 8'h88);
    wr(8'h0A, 8'h82); rd(8'h0A, r); check("R6 clear", r, 8'h80);
    srcs(5'd0); @(negedge clk);

    // R7 flag bit read-only, enable writable
    wr(8'h0A, 8'h88); rd(8'h0A, r); check("R7 flag read-only", r, 8'h80);
    wr(8'h0A, 8'h00); rd(8'h0A, r); check("R7 enable cleared", r, 8'h00);
    wr(8'h0A, 8'h80); rd(8'h0A, r); check("R7 enable set", r, 8'h80);

    // R8 unused bits, other addresses
    wr(8'h0A, 8'h75); rd(8'h0A, r); check("R8 unused bits zero", r, 8'h00);
    wr(8'h0A, 8'h80);
    wr(8'h0B, 8'h00); rd(8'h0A, r); check("R8 foreign write ignored", r, 8'h80);
    srcs(5'd1); @(negedge clk);
    rd(8'h0B, r); check("R8 foreign read zero", r, 8'h00);
    wr(8'h09, 8'h02); srcs(5'd0);
    rd(8'h0A, r); check("R8 foreign clear ignored", r, 8'h88);

    // R9 output gating
    check("R9 irq asserted", {7'd0, irq_to_cpu}, 8'h01);
    cpu_mask = 1'b1; #1; check("R9 mask blocks", {7'd0, irq_to_cpu}, 8'h00);
    cpu_mask = 1'b0;
    wr(8'h0A, 8'h02); rd(8'h0A, r); check("R9 cleared disabled", r, 8'h00);
    srcs(5'd1); @(negedge clk); srcs(5'd0);
    rd(8'h0A, r); check("R9 flag latches while disabled", r, 8'h08);
    check("R9 irq off while disabled", {7'd0, irq_to_cpu}, 8'h00);
    wr(8'h0A, 8'h80);
    check("R9 irq after enable", {7'd0, irq_to_cpu}, 8'h01);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule